// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block holds the status byte of a 2K×8 serial memory and decides, cycle by cycle, whether a write may go ahead. The command layer sends it one-cycle pulses for the set-latch and clear-latch commands and for the two stages of a status write. The first stage says that the status-write opcode has been accepted and its data byte is being shifted in. The second stage says that the byte is complete and the select line has risen, so the timed cycle may start. The write timer supplies a busy level and a one-cycle done pulse at the end of every byte, page or status write cycle. The array datapath presents a target address and gets back a flag that tells it whether that address may be programmed.

Protection works on two levels. A two-bit block-protect code locks the top quarter, the top half or the whole array. A protect-enable bit, together with an active-low protect pin, locks the status register itself, including the enable bit. A status write is taken in two steps. The data byte is staged when the commit pulse arrives, and it lands in the register only when the timed cycle completes. The protection bits are plain flops that take parameter values at reset, and every output is registered.

Top module: `sr_guard_unit`

## Requirements
- R1: When not busy, `status_q` presents, one cycle after the state changes, bit 7 = protect enable, bits 6..4 = 0, bits 3..2 = block-protect code (bit 3 the high bit), bit 1 = write enable latch and bit 0 = 0.
- R2: If `wr_busy` is high in a cycle, `status_q` reads 8'hFF in the next cycle.
- R3: The write enable latch is set by `wren_cmd` and cleared by `wrdi_cmd`. When both arrive in the same cycle, the clear wins. A `wr_done` pulse clears the latch and takes priority over both commands.
- R4: Block-protect code 00 locks no address, 01 locks 0x600..0x7FF, 10 locks 0x400..0x7FF and 11 locks 0x000..0x7FF. In general, the codes lock the top quarter, the top half or all of the address space.
- R5: One cycle after `addr` is presented, `array_wr_ok` is 1 exactly when the latch is set and the address is not locked.
- R6: Hardware lock is active when `wp_n` is 0 and the enable bit is 1. While the lock is active, `status_wr_ok` is 0 and a status write commit is refused.
- R7: A status write commit is accepted only when the latch is set. `status_wr_ok` is 1 one cycle after the latch is set and the hardware lock is inactive.
- R8: An accepted status write takes only bits 7, 3 and 2 of `srw_data`. The other data bits never show up in the status byte.
- R9: If the hardware lock becomes active between `srw_begin` and `srw_commit`, the pending write is cancelled. After a commit has been accepted, the pin has no effect on it.
- R10: Bits 7, 3 and 2 change only on the `wr_done` pulse that follows an accepted commit, and not at the commit itself.
- R11: At reset, the protect enable bit and the block-protect code load the parameters `INIT_WPEN` and `INIT_BP` (both 0 by default), and the latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_cmd | input | 1 | Set-latch command pulse |
| wrdi_cmd | input | 1 | Clear-latch command pulse |
| srw_begin | input | 1 | Status-write opcode accepted, data byte being shifted |
| srw_commit | input | 1 | Status-write data complete, request to start the timed cycle |
| srw_data | input | 8 | Status-write data byte, valid with `srw_commit` |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_busy | input | 1 | Write timer busy |
| wr_done | input | 1 | One-cycle pulse at the end of any write cycle |
| addr | input | ADDR_W | Array address under test |
| status_q | output | 8 | Readable status byte |
| array_wr_ok | output | 1 | Array write to `addr` permitted |
| status_wr_ok | output | 1 | Status write permitted |

## Verification
The bench targets the address boundaries of each block-protect code (0x3FF/0x400 and 0x5FF/0x600). A decoder that is off by one quarter would grant or refuse writes on the wrong side of one of these addresses. It drives a protect-pin pulse inside the status-write shift window and another inside the timed cycle. A design that ignores the first would apply a write it should have dropped, and a design that honours the second would drop a committed write. It writes bytes with the ignored bits set and checks the status between the commit and the done pulse. This catches a register that stores stray bits or that updates early. It also issues the set and clear commands in the same cycle, and a set command in the same cycle as a done pulse, which exposes a wrong latch priority.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int STAT_W      = 8;
  localparam int BIT_WPEN    = 7;
  localparam int BIT_BP_HI   = 3;
  localparam int BIT_BP_LO   = 2;
  localparam int BIT_LATCH   = 1;
  localparam int BIT_BUSY    = 0;
  localparam int NUM_QUARTER = 4;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_bits_t;

  // Lock rule for one quarter of the array under a block-protect code
  function automatic logic quarter_locked(input logic [1:0] code, input int q);
    case (code)
      2'b01:   return (q == NUM_QUARTER - 1);
      2'b10:   return (q >= NUM_QUARTER / 2);
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sr_zone_decode.sv
module sr_zone_decode
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int QSEL_LO = ADDR_W - 2;

  logic [NUM_QUARTER-1:0] q_lock;

  genvar q;
  generate
    for (q = 0; q < NUM_QUARTER; q++) begin : g_quarter
      assign q_lock[q] = quarter_locked(code, q);
    end
  endgenerate

  assign locked = q_lock[addr[ADDR_W-1:QSEL_LO]];
endmodule

// File: rtl/sr_enable_latch.sv
module sr_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic cycle_done,
  output logic latch_q
);
  always_ff @(posedge clk) begin
    if (rst)             latch_q <= 1'b0;
    else if (cycle_done) latch_q <= 1'b0;
    else if (clr_cmd)    latch_q <= 1'b0;
    else if (set_cmd)    latch_q <= 1'b1;
  end
endmodule

// File: rtl/sr_stage.sv
module sr_stage
  import sr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              begin_pulse,
  input  logic              commit_pulse,
  input  logic [STAT_W-1:0] data,
  input  logic              hw_lock,
  input  logic              latch_set,
  input  logic              cycle_done,
  output logic              apply,
  output nv_bits_t          staged_bits
);
  logic pending_q;
  logic staged_q;
  logic accept;

  assign accept = commit_pulse && pending_q && latch_set && !hw_lock;
  assign apply  = cycle_done && staged_q;

  always_ff @(posedge clk) begin
    if (rst)                             pending_q <= 1'b0;
    else if (begin_pulse)                pending_q <= 1'b1;
    else if (commit_pulse || hw_lock)    pending_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q    <= 1'b0;
      staged_bits <= '0;
    end else if (accept) begin
      staged_q         <= 1'b1;
      staged_bits.wpen <= data[BIT_WPEN];
      staged_bits.bp   <= data[BIT_BP_HI:BIT_BP_LO];
    end else if (cycle_done) begin
      staged_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sr_guard_unit.sv
module sr_guard_unit
  import sr_guard_pkg::*;
#(
  parameter int         ADDR_W    = 11,
  parameter logic       INIT_WPEN = 1'b0,
  parameter logic [1:0] INIT_BP   = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wren_cmd,
  input  logic              wrdi_cmd,
  input  logic              srw_begin,
  input  logic              srw_commit,
  input  logic [7:0]        srw_data,
  input  logic              wp_n,
  input  logic              wr_busy,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_q,
  output logic              array_wr_ok,
  output logic              status_wr_ok
);
  logic       wel_q;
  logic       wpen_q;
  logic [1:0] bp_q;
  logic       hw_lock;
  logic       addr_locked;
  logic       apply;
  nv_bits_t   staged_bits;
  logic [STAT_W-1:0] idle_byte;

  assign hw_lock = !wp_n && wpen_q;

  sr_enable_latch u_latch (
    .clk(clk), .rst(rst), .set_cmd(wren_cmd), .clr_cmd(wrdi_cmd),
    .cycle_done(wr_done), .latch_q(wel_q)
  );

  sr_stage u_stage (
    .clk(clk), .rst(rst), .begin_pulse(srw_begin), .commit_pulse(srw_commit),
    .data(srw_data), .hw_lock(hw_lock), .latch_set(wel_q),
    .cycle_done(wr_done), .apply(apply), .staged_bits(staged_bits)
  );

  sr_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
    .code(bp_q), .addr(addr), .locked(addr_locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wpen_q <= INIT_WPEN;
      bp_q   <= INIT_BP;
    end else if (apply) begin
      wpen_q <= staged_bits.wpen;
      bp_q   <= staged_bits.bp;
    end
  end

  always_comb begin
    idle_byte            = '0;
    idle_byte[BIT_WPEN]  = wpen_q;
    idle_byte[BIT_BP_HI] = bp_q[1];
    idle_byte[BIT_BP_LO] = bp_q[0];
    idle_byte[BIT_LATCH] = wel_q;
    idle_byte[BIT_BUSY]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q     <= '0;
      array_wr_ok  <= 1'b0;
      status_wr_ok <= 1'b0;
    end else begin
      status_q     <= wr_busy ? '1 : idle_byte;
      array_wr_ok  <= wel_q && !addr_locked;
      status_wr_ok <= wel_q && !hw_lock;
    end
  end
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic       wr_busy,
  input logic       wr_done,
  input logic [7:0] status_q,
  input logic       array_wr_ok,
  input logic       status_wr_ok,
  input logic       wel,
  input logic       wpen,
  input logic [1:0] bp
);
  // R2
  busy_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
    wr_busy |=> status_q == 8'hFF);
  // R1
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_busy |=> status_q[6:4] == 3'b000 && !status_q[0]);
  // R3
  done_clears_latch_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wel);
  // R6
  hw_lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && wpen) |=> !status_wr_ok);
  // R5
  no_latch_no_array_chk: assert property (@(posedge clk) disable iff (rst)
    !wel |=> !array_wr_ok);
  // R4
  full_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (bp == 2'b11) |=> !array_wr_ok);
  // R10
  nv_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_done |=> $stable(wpen) && $stable(bp));
endmodule

bind sr_guard_unit sr_guard_chk u_sr_guard_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .wr_busy(wr_busy), .wr_done(wr_done),
  .status_q(status_q), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok),
  .wel(wel_q), .wpen(wpen_q), .bp(bp_q)
);

// File: tb/test_sr_guard_unit.sv
module test_sr_guard_unit;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst;
  logic wren_cmd, wrdi_cmd, srw_begin, srw_commit, wp_n, wr_busy, wr_done;
  logic [7:0] srw_data;
  logic [AW-1:0] addr;
  logic [7:0] status_q;
  logic array_wr_ok, status_wr_ok;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  bit m_wel, m_wpen;
  bit [1:0] m_bp;

  always #4 clk = ~clk;

  sr_guard_unit #(.ADDR_W(AW)) i_sr_guard_unit (
    .clk(clk), .rst(rst), .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd),
    .srw_begin(srw_begin), .srw_commit(srw_commit), .srw_data(srw_data),
    .wp_n(wp_n), .wr_busy(wr_busy), .wr_done(wr_done), .addr(addr),
    .status_q(status_q), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
  );

  function automatic bit exp_locked(bit [1:0] code, bit [AW-1:0] a);
    case (code)
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [7:0] exp_status();
    return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  function automatic bit exp_sr_ok();
    return m_wel && !(!wp_n && m_wpen);
  endfunction

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_pulses();
    wren_cmd = 0; wrdi_cmd = 0; srw_begin = 0; srw_commit = 0;
    wr_done = 0; wr_busy = 0;
  endtask

  task automatic check_state(string req);
    cyc(2);
    cmp(req, status_q, exp_status());
    cmp("R6/R7 status_wr_ok", {7'd0, status_wr_ok}, {7'd0, exp_sr_ok()});
  endtask

  task automatic probe(bit [AW-1:0] a);
    addr = a;
    cyc(1);
    cmp($sformatf("R4/R5 addr %h bp %0d", a, m_bp), {7'd0, array_wr_ok},
        {7'd0, m_wel && !exp_locked(m_bp, a)});
  endtask

  task automatic latch_cmd(bit s, bit c);
    wren_cmd = s; wrdi_cmd = c;
    cyc(1);
    clear_pulses();
    if (c) m_wel = 0; else if (s) m_wel = 1;
  endtask

  task automatic timed_cycle(int n);
    wr_busy = 1;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      cmp("R2 busy", status_q, 8'hFF);
    end
    wr_busy = 0; wr_done = 1;
    cyc(1);
    clear_pulses();
  endtask

  // glitch_pre: pin low inside shift window; glitch_post: pin low in timed cycle
  task automatic status_write(bit [7:0] d, bit glitch_pre, bit glitch_post);
    bit base_wp = wp_n;
    bit cancel = 0;
    bit accept;
    srw_begin = 1;
    cyc(1);
    clear_pulses();
    if (glitch_pre) begin
      wp_n = 0;
      if (m_wpen) cancel = 1;
      cyc(1);
      wp_n = base_wp;
    end
    srw_data = d; srw_commit = 1;
    accept = !cancel && m_wel && !(!wp_n && m_wpen);
    cyc(1);
    clear_pulses();
    // R10: nothing lands before the done pulse
    cyc(2);
    cmp("R10 before done", status_q, exp_status());
    if (glitch_post) wp_n = 0;
    timed_cycle(3);
    wp_n = base_wp;
    m_wel = 0;
    if (accept) begin m_wpen = d[7]; m_bp = d[3:2]; end
  endtask

  initial begin
    clear_pulses();
    srw_data = 0; addr = 0; wp_n = 1; rst = 1;
    cyc(3);
    rst = 0;
    m_wel = 0; m_wpen = 0; m_bp = 0;
    cyc(1);
    // R11 reset state
    cmp("R11 reset status", status_q, 8'h00);
    cmp("R11 reset array_ok", {7'd0, array_wr_ok}, 8'h00);
    // R3 latch set/clear, clear wins
    latch_cmd(1, 0); check_state("R3 set");
    latch_cmd(1, 1); check_state("R3 both, clear wins");
    latch_cmd(1, 0);
    wren_cmd = 1; wr_done = 1; cyc(1); clear_pulses(); m_wel = 0;
    check_state("R3 done beats set");
    // R7 status write refused without latch
    status_write(8'h8C, 0, 0); check_state("R7 no latch refused");
    // R8 ignored bits
    latch_cmd(1, 0); status_write(8'h73, 0, 0); check_state("R8 ignored bits");
    // code 01 boundaries
    latch_cmd(1, 0); status_write(8'h04, 0, 0); check_state("R1 bp=01");
    latch_cmd(1, 0);
    probe(11'h5FF); probe(11'h600); probe(11'h7FF); probe(11'h000);
    // code 10
    status_write(8'h08, 0, 0); latch_cmd(1, 0);
    probe(11'h3FF); probe(11'h400); probe(11'h5FF);
    // enable + code 11, then hardware lock
    status_write(8'h8C, 0, 0); latch_cmd(1, 0); check_state("R1 wpen bp=11");
    probe(11'h000); probe(11'h3FF);
    wp_n = 0; check_state("R6 pin low");
    status_write(8'h00, 0, 0); check_state("R6 refused under lock");
    wp_n = 1;
    // R9 glitch in shift window cancels
    latch_cmd(1, 0); status_write(8'h00, 1, 0); check_state("R9 cancelled");
    // R9 glitch after commit has no effect
    latch_cmd(1, 0); status_write(8'h04, 0, 1); check_state("R9 post commit applies");
    // random
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      wp_n = $urandom_range(0, 3) != 0;
      case (op)
        0: latch_cmd(1, 0);
        1: latch_cmd($urandom_range(0, 1), 1);
        2: status_write(8'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
        3: begin timed_cycle($urandom_range(1, 4)); m_wel = 0; end
        default: probe(AW'($urandom));
      endcase
      check_state("R1 random");
      probe(AW'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule